// File: doc/BRIEF.md
# Flash Bus Device-Side Command Front End

This block sits on the device side of a byte-wide flash bus. Every bus input is oversampled on the core clock through two-flop synchronisers. A byte on the shared I/O lines is captured only when the active-low write strobe rises. At that moment the two latch qualifiers decide what the byte is: a command, an address cycle or a data byte. Each falling edge of the active-low read strobe steps a column counter. The first two address bytes after a command preload that counter.

A small set of confirm commands starts a timed busy period that stands in for the array operation. While it runs, the active-low ready/busy line is pulled low through an open-drain enable. The block also models four further behaviours:
- Program and erase confirms are refused while write protect is held low.
- Deselecting the chip during a busy period does not drop the device into standby until the operation ends.
- Bus bytes are not taken until a power-up recovery count has expired.
- The I/O output enable is raised only for a selected, idle device with its read strobe low.

Top module: `flash_bus_front`

## Requirements
- R1: Bus bytes are captured only at a rising edge of `weN`, and only while `ceN` is low, the device is idle and recovery is over. Each accepted edge raises at most one of `cmdStrobe`, `addrStrobe` or `dataStrobe`, for a single cycle, and updates `busByte`.
- R2: A byte captured with `cle` high and `ale` low is a command. `cmdStrobe` pulses and `busByte` shows the byte.
- R3: A byte captured with `ale` high and `cle` low is an address. `addrStrobe` pulses. The first address byte after an accepted command loads `colAddr[7:0]` and the second loads `colAddr[15:8]`. Any further address bytes leave `colAddr` unchanged.
- R4: A byte captured with both `cle` and `ale` low is data. `dataStrobe` pulses, `busByte` shows the byte, and `colAddr` is not altered.
- R5: A byte captured with both `cle` and `ale` high is illegal. No strobe pulses and `busByte` keeps its old value.
- R6: Each falling edge of `reN` while the device is selected, idle and recovered adds one to `colAddr`, wrapping from all ones to zero.
- R7: The command bytes 0x30 (read), 0x10 (program) and 0xD0 (erase) start a busy period. During it `rbDrvLow` is high for exactly READ_BUSY, PROG_BUSY or ERASE_BUSY clock cycles respectively.
- R8: While `wpN` is low, 0x10 and 0xD0 are refused: no `cmdStrobe` and no busy period. 0x30 is still accepted.
- R9: If `ceN` goes high while `rbDrvLow` is high, `inStandby` stays low until the busy period ends and then rises.
- R10: `ioOe` is high only while `ceN` and `reN` are both low, the device is idle and recovery is over.
- R11: Write-strobe edges before RECOVERY clock cycles have passed since reset produce no strobe.
- R12: Write-strobe and read-strobe edges during a busy period produce no strobe and do not move `colAddr`.
- R13: With `ceN` high and the device idle, write-strobe and read-strobe edges have no effect on the strobes or on `colAddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core oversampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| weN | input | 1 | Bus write strobe, active low; byte captured on its rising edge |
| reN | input | 1 | Bus read strobe, active low; column steps on its falling edge |
| ceN | input | 1 | Chip select, active low |
| cle | input | 1 | Command latch qualifier |
| ale | input | 1 | Address latch qualifier |
| wpN | input | 1 | Write protect, active low |
| ioIn | input | 8 | Shared I/O bus, input side |
| ioOe | output | 1 | Output enable for the I/O bus drivers |
| rbDrvLow | output | 1 | Open-drain pull-down enable for ready/busy (1 = busy) |
| inStandby | output | 1 | Device is deselected and idle |
| cmdStrobe | output | 1 | One-cycle pulse: command byte accepted |
| addrStrobe | output | 1 | One-cycle pulse: address byte accepted |
| dataStrobe | output | 1 | One-cycle pulse: data byte accepted |
| busByte | output | 8 | Last accepted bus byte |
| colAddr | output | COL_W | Column address counter |

## Verification
The hardest situation to reach is a bus cycle that arrives while the device is busy, and in particular a chip deselect that lands inside the busy window. Ports alone give only a few cycles to do this. The bench sets the erase busy length well above the length of a full write-strobe or read-strobe cycle. It then issues a data write and a read pulse straight after the erase confirm, and lifts chip select before the timer expires. This shows the ignored strobes, the frozen column and the held selection while the busy line is still low.

// File: rtl/fbf_pkg.sv
package fbf_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic captureByte;
    logic loadColLo;
    logic loadColHi;
    logic incCol;
  } dpCtl_t;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_PROG  = 2'd2,
    OP_ERASE = 2'd3
  } opKind_t;

  localparam logic [7:0] CMD_READ_GO  = 8'h30;
  localparam logic [7:0] CMD_PROG_GO  = 8'h10;
  localparam logic [7:0] CMD_ERASE_GO = 8'hD0;

endpackage

// File: rtl/fbf_sync.sv
module fbf_sync #(
  parameter int WIDTH = 8,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) stg[s] <= RST_VAL;
        else       stg[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) stg[s] <= RST_VAL;
        else       stg[s] <= stg[s-1];
      end
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/fbf_ctrl.sv
module fbf_ctrl import fbf_pkg::*; #(
  parameter int RECOVERY   = 1000,
  parameter int READ_BUSY  = 25,
  parameter int PROG_BUSY  = 200,
  parameter int ERASE_BUSY = 2000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       weS,
  input  logic       reS,
  input  logic       ceS,
  input  logic       wpS,
  input  logic       cleS,
  input  logic       aleS,
  input  logic [7:0] ioS,
  output dpCtl_t     ctl,
  output logic       cmdStrobe,
  output logic       addrStrobe,
  output logic       dataStrobe,
  output logic       busy,
  output logic       ioOe,
  output logic       inStandby,
  output logic       ready
);

  localparam int MAXB_RP = (READ_BUSY > PROG_BUSY) ? READ_BUSY : PROG_BUSY;
  localparam int MAXB    = (MAXB_RP > ERASE_BUSY) ? MAXB_RP : ERASE_BUSY;
  localparam int BUSY_W  = $clog2(MAXB + 1);
  localparam int REC_W   = $clog2(RECOVERY + 2);

  // Power-up recovery counter
  logic [REC_W-1:0] recCnt;
  assign ready = (recCnt == REC_W'(RECOVERY));

  always_ff @(posedge clk) begin
    if (!rstN)      recCnt <= '0;
    else if (!ready) recCnt <= recCnt + 1'b1;
  end

  // Edge detection on synchronised strobes
  logic wePrev, rePrev;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wePrev <= 1'b1;
      rePrev <= 1'b1;
    end else begin
      wePrev <= weS;
      rePrev <= reS;
    end
  end

  logic weRise, reFall, accept;
  logic busyQ;
  assign weRise = weS & ~wePrev;
  assign reFall = ~reS & rePrev;
  assign accept = weRise & ~ceS & ready & ~busyQ;

  // Byte classification
  logic isCmd, isAddr, isData;
  assign isCmd  = accept &  cleS & ~aleS;
  assign isAddr = accept & ~cleS &  aleS;
  assign isData = accept & ~cleS & ~aleS;

  function automatic opKind_t decodeOp(input logic [7:0] b);
    case (b)
      CMD_READ_GO:  return OP_READ;
      CMD_PROG_GO:  return OP_PROG;
      CMD_ERASE_GO: return OP_ERASE;
      default:      return OP_NONE;
    endcase
  endfunction

  opKind_t reqOp;
  logic    needWp, rejected, takeCmd, startOp;
  logic [BUSY_W-1:0] busyLen;

  assign reqOp    = decodeOp(ioS);
  assign needWp   = (reqOp == OP_PROG) || (reqOp == OP_ERASE);
  assign rejected = isCmd & needWp & ~wpS;
  assign takeCmd  = isCmd & ~rejected;
  assign startOp  = takeCmd & (reqOp != OP_NONE);

  always_comb begin
    case (reqOp)
      OP_READ:  busyLen = BUSY_W'(READ_BUSY - 1);
      OP_PROG:  busyLen = BUSY_W'(PROG_BUSY - 1);
      OP_ERASE: busyLen = BUSY_W'(ERASE_BUSY - 1);
      default:  busyLen = '0;
    endcase
  end

  // Address cycle index since last command
  logic [1:0] addrIdx;
  always_ff @(posedge clk) begin
    if (!rstN)                           addrIdx <= 2'd0;
    else if (takeCmd)                    addrIdx <= 2'd0;
    else if (isAddr && addrIdx != 2'd2)  addrIdx <= addrIdx + 2'd1;
  end

  always_comb begin
    ctl.captureByte = takeCmd | isAddr | isData;
    ctl.loadColLo   = isAddr & (addrIdx == 2'd0);
    ctl.loadColHi   = isAddr & (addrIdx == 2'd1);
    ctl.incCol      = reFall & ~ceS & ready & ~busyQ;
  end

  // Registered kind strobes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdStrobe  <= 1'b0;
      addrStrobe <= 1'b0;
      dataStrobe <= 1'b0;
    end else begin
      cmdStrobe  <= takeCmd;
      addrStrobe <= isAddr;
      dataStrobe <= isData;
    end
  end

  // Busy timer
  logic [BUSY_W-1:0] busyCnt;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      busyCnt <= '0;
    end else if (startOp) begin
      busyQ   <= 1'b1;
      busyCnt <= busyLen;
    end else if (busyQ) begin
      if (busyCnt == '0) busyQ <= 1'b0;
      else               busyCnt <= busyCnt - 1'b1;
    end
  end

  assign busy      = busyQ;
  assign ioOe      = ~ceS & ~reS & ~busyQ & ready;
  assign inStandby = ceS & ~busyQ;

endmodule

// File: rtl/fbf_dp.sv
module fbf_dp import fbf_pkg::*; #(
  parameter int COL_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [7:0]       ioS,
  output logic [7:0]       busByte,
  output logic [COL_W-1:0] colAddr
);

  localparam int HI_W = COL_W - 8;

  always_ff @(posedge clk) begin
    if (!rstN)                busByte <= '0;
    else if (ctl.captureByte) busByte <= ioS;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              colAddr <= '0;
    else if (ctl.loadColLo) colAddr[7:0] <= ioS;
    else if (ctl.loadColHi) colAddr[COL_W-1:8] <= ioS[HI_W-1:0];
    else if (ctl.incCol)    colAddr <= colAddr + 1'b1;
  end

endmodule

// File: rtl/flash_bus_front.sv
module flash_bus_front import fbf_pkg::*; #(
  parameter int COL_W      = 16,
  parameter int RECOVERY   = 1000,
  parameter int READ_BUSY  = 25,
  parameter int PROG_BUSY  = 200,
  parameter int ERASE_BUSY = 2000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             weN,
  input  logic             reN,
  input  logic             ceN,
  input  logic             cle,
  input  logic             ale,
  input  logic             wpN,
  input  logic [7:0]       ioIn,
  output logic             ioOe,
  output logic             rbDrvLow,
  output logic             inStandby,
  output logic             cmdStrobe,
  output logic             addrStrobe,
  output logic             dataStrobe,
  output logic [7:0]       busByte,
  output logic [COL_W-1:0] colAddr
);

  localparam int SYNC_W = 14;
  localparam logic [SYNC_W-1:0] SYNC_RST = {4'b1110, 10'b0};

  logic [SYNC_W-1:0] syncOut;
  logic weS, reS, ceS, wpS, cleS, aleS;
  logic [7:0] ioS;

  fbf_sync #(.WIDTH(SYNC_W), .STAGES(2), .RST_VAL(SYNC_RST)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({weN, reN, ceN, wpN, cle, ale, ioIn}),
    .dout (syncOut)
  );

  assign {weS, reS, ceS, wpS, cleS, aleS, ioS} = syncOut;

  dpCtl_t ctl;
  logic   busy, ready;

  fbf_ctrl #(
    .RECOVERY(RECOVERY), .READ_BUSY(READ_BUSY),
    .PROG_BUSY(PROG_BUSY), .ERASE_BUSY(ERASE_BUSY)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .weS(weS), .reS(reS), .ceS(ceS), .wpS(wpS),
    .cleS(cleS), .aleS(aleS), .ioS(ioS),
    .ctl(ctl),
    .cmdStrobe(cmdStrobe), .addrStrobe(addrStrobe), .dataStrobe(dataStrobe),
    .busy(busy), .ioOe(ioOe), .inStandby(inStandby), .ready(ready)
  );

  fbf_dp #(.COL_W(COL_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .ioS(ioS),
    .busByte(busByte), .colAddr(colAddr)
  );

  assign rbDrvLow = busy;

  // Observation points for the bound checker
  logic colStep, colLoad;
  assign colStep = ctl.incCol;
  assign colLoad = ctl.loadColLo | ctl.loadColHi;

endmodule

// File: rtl/fbf_checker.sv
module fbf_checker #(
  parameter int COL_W    = 16,
  parameter int MAX_BUSY = 2000
) (
  input logic             clk,
  input logic             rstN,
  input logic             ioOe,
  input logic             rbDrvLow,
  input logic             inStandby,
  input logic             cmdStrobe,
  input logic             addrStrobe,
  input logic             dataStrobe,
  input logic             ready,
  input logic             colStep,
  input logic             colLoad,
  input logic [COL_W-1:0] colAddr
);

  localparam int RUN_W = $clog2(MAX_BUSY + 2);
  logic [RUN_W-1:0] busyRun;

  always_ff @(posedge clk) begin
    if (!rstN)         busyRun <= '0;
    else if (rbDrvLow) busyRun <= busyRun + 1'b1;
    else               busyRun <= '0;
  end

  p_one_kind_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmdStrobe, addrStrobe, dataStrobe}));

  p_col_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (colStep && !colLoad) |=> colAddr == $past(colAddr) + 1'b1);

  p_busy_bounded_r7: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= RUN_W'(MAX_BUSY));

  p_stay_selected_r9: assert property (@(posedge clk) disable iff (!rstN)
    rbDrvLow |-> !inStandby);

  p_oe_quiet_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    rbDrvLow |-> !ioOe);

  p_recovery_gate_r11: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ready) |-> !(cmdStrobe || addrStrobe || dataStrobe));

  p_quiet_busy_r12: assert property (@(posedge clk) disable iff (!rstN)
    rbDrvLow |=> !(cmdStrobe || addrStrobe || dataStrobe));

endmodule

bind flash_bus_front fbf_checker #(
  .COL_W(COL_W),
  .MAX_BUSY((READ_BUSY > PROG_BUSY) ?
              ((READ_BUSY > ERASE_BUSY) ? READ_BUSY : ERASE_BUSY) :
              ((PROG_BUSY > ERASE_BUSY) ? PROG_BUSY : ERASE_BUSY))
) u_chk (
  .clk(clk), .rstN(rstN), .ioOe(ioOe), .rbDrvLow(rbDrvLow),
  .inStandby(inStandby), .cmdStrobe(cmdStrobe), .addrStrobe(addrStrobe),
  .dataStrobe(dataStrobe), .ready(ready), .colStep(colStep),
  .colLoad(colLoad), .colAddr(colAddr)
);

// File: tb/flash_bus_front_tb.sv
module flash_bus_front_tb;

  localparam int COL_W = 16;
  localparam int REC   = 30;
  localparam int RDB   = 6;
  localparam int PGB   = 12;
  localparam int ERB   = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic weN = 1'b1, reN = 1'b1, ceN = 1'b1, cle = 1'b0, ale = 1'b0, wpN = 1'b1;
  logic [7:0] ioIn = 8'h00;
  logic ioOe, rbDrvLow, inStandby, cmdStrobe, addrStrobe, dataStrobe;
  logic [7:0] busByte;
  logic [COL_W-1:0] colAddr;

  always #10 clk = ~clk;

  flash_bus_front #(
    .COL_W(COL_W), .RECOVERY(REC), .READ_BUSY(RDB),
    .PROG_BUSY(PGB), .ERASE_BUSY(ERB)
  ) u_dut (
    .clk(clk), .rstN(rstN), .weN(weN), .reN(reN), .ceN(ceN),
    .cle(cle), .ale(ale), .wpN(wpN), .ioIn(ioIn),
    .ioOe(ioOe), .rbDrvLow(rbDrvLow), .inStandby(inStandby),
    .cmdStrobe(cmdStrobe), .addrStrobe(addrStrobe), .dataStrobe(dataStrobe),
    .busByte(busByte), .colAddr(colAddr)
  );

  int total = 0;
  int fails = 0;
  int cmdCnt = 0, addrCnt = 0, dataCnt = 0, busyCycles = 0;

  always @(negedge clk) begin
    if (cmdStrobe)  cmdCnt++;
    if (addrStrobe) addrCnt++;
    if (dataStrobe) dataCnt++;
    if (rbDrvLow)   busyCycles++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wrCycle(input logic c, input logic a, input logic [7:0] b);
    @(negedge clk); cle = c; ale = a; ioIn = b; weN = 1'b0;
    repeat (3) @(negedge clk);
    weN = 1'b1;
    repeat (4) @(negedge clk);
    cle = 1'b0; ale = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic rdPulse();
    @(negedge clk); reN = 1'b0;
    repeat (4) @(negedge clk);
    reN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(rbDrvLow == 1'b0, "R7 reset busy", rbDrvLow, 0);
    chk(ioOe == 1'b0, "R10 reset oe", ioOe, 0);
    chk(colAddr == '0, "R6 reset col", colAddr, 0);
    chk(inStandby == 1'b1, "R9 reset standby", inStandby, 1);
  endtask

  task automatic t_recovery();
    int c0 = cmdCnt;
    ceN = 1'b0;
    wrCycle(1'b1, 1'b0, 8'h00);
    chk(cmdCnt == c0, "R11 early command ignored", cmdCnt - c0, 0);
    repeat (REC + 10) @(negedge clk);
  endtask

  task automatic t_cmd();
    int c0 = cmdCnt;
    wrCycle(1'b1, 1'b0, 8'h00);
    chk(cmdCnt == c0 + 1, "R2 command strobe", cmdCnt - c0, 1);
    chk(busByte == 8'h00, "R2 command byte", busByte, 8'h00);
  endtask

  task automatic t_addr();
    int a0 = addrCnt;
    wrCycle(1'b0, 1'b1, 8'h34);
    wrCycle(1'b0, 1'b1, 8'h12);
    wrCycle(1'b0, 1'b1, 8'h99);
    chk(addrCnt == a0 + 3, "R3 address strobes", addrCnt - a0, 3);
    chk(colAddr == 16'h1234, "R3 column load", colAddr, 16'h1234);
    chk(busByte == 8'h99, "R1 last byte", busByte, 8'h99);
  endtask

  task automatic t_data();
    int d0 = dataCnt;
    wrCycle(1'b0, 1'b0, 8'h5A);
    chk(dataCnt == d0 + 1, "R4 data strobe", dataCnt - d0, 1);
    chk(busByte == 8'h5A, "R4 data byte", busByte, 8'h5A);
    chk(colAddr == 16'h1234, "R4 column kept", colAddr, 16'h1234);
  endtask

  task automatic t_both();
    int s0 = cmdCnt + addrCnt + dataCnt;
    wrCycle(1'b1, 1'b1, 8'hEE);
    chk(cmdCnt + addrCnt + dataCnt == s0, "R5 illegal no strobe",
        cmdCnt + addrCnt + dataCnt - s0, 0);
    chk(busByte == 8'h5A, "R5 byte kept", busByte, 8'h5A);
  endtask

  task automatic t_read_step();
    for (int i = 0; i < 3; i++) rdPulse();
    chk(colAddr == 16'h1237, "R6 column steps", colAddr, 16'h1237);
    wrCycle(1'b1, 1'b0, 8'h00);
    wrCycle(1'b0, 1'b1, 8'hFF);
    wrCycle(1'b0, 1'b1, 8'hFF);
    chk(colAddr == 16'hFFFF, "R3 column full", colAddr, 16'hFFFF);
    rdPulse();
    chk(colAddr == 16'h0000, "R6 column wrap", colAddr, 0);
  endtask

  task automatic t_oe();
    @(negedge clk); reN = 1'b0;
    repeat (4) @(negedge clk);
    chk(ioOe == 1'b1, "R10 oe with read low", ioOe, 1);
    reN = 1'b1;
    repeat (4) @(negedge clk);
    chk(ioOe == 1'b0, "R10 oe released", ioOe, 0);
  endtask

  task automatic t_busy(input logic [7:0] code, input int len, input string tag);
    busyCycles = 0;
    wrCycle(1'b1, 1'b0, code);
    repeat (ERB + 10) @(negedge clk);
    chk(busyCycles == len, tag, busyCycles, len);
  endtask

  task automatic t_busy_ignore();
    int d0 = dataCnt;
    logic [COL_W-1:0] c0 = colAddr;
    busyCycles = 0;
    wrCycle(1'b1, 1'b0, 8'hD0);
    chk(rbDrvLow == 1'b1, "R7 erase busy", rbDrvLow, 1);
    wrCycle(1'b0, 1'b0, 8'hA5);
    @(negedge clk); reN = 1'b0;
    repeat (4) @(negedge clk);
    chk(ioOe == 1'b0, "R10 oe off busy", ioOe, 0);
    reN = 1'b1;
    repeat (3) @(negedge clk);
    chk(dataCnt == d0, "R12 data ignored busy", dataCnt - d0, 0);
    chk(colAddr == c0, "R12 column frozen busy", colAddr, c0);
    repeat (ERB + 10) @(negedge clk);
    chk(busyCycles == ERB, "R7 erase length", busyCycles, ERB);
  endtask

  task automatic t_wp();
    int c0;
    wpN = 1'b0;
    repeat (4) @(negedge clk);
    c0 = cmdCnt; busyCycles = 0;
    wrCycle(1'b1, 1'b0, 8'h10);
    wrCycle(1'b1, 1'b0, 8'hD0);
    repeat (5) @(negedge clk);
    chk(cmdCnt == c0, "R8 protected commands refused", cmdCnt - c0, 0);
    chk(busyCycles == 0, "R8 no busy when protected", busyCycles, 0);
    t_busy(8'h30, RDB, "R8 read allowed protected");
    wpN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_ce_busy();
    wrCycle(1'b1, 1'b0, 8'hD0);
    ceN = 1'b1;
    repeat (4) @(negedge clk);
    chk(inStandby == 1'b0, "R9 held selected busy", inStandby, 0);
    chk(rbDrvLow == 1'b1, "R9 still busy", rbDrvLow, 1);
    repeat (ERB + 5) @(negedge clk);
    chk(inStandby == 1'b1, "R9 standby after busy", inStandby, 1);
  endtask

  task automatic t_ce_high();
    int s0 = cmdCnt + addrCnt + dataCnt;
    logic [COL_W-1:0] c0 = colAddr;
    wrCycle(1'b1, 1'b0, 8'h00);
    wrCycle(1'b0, 1'b0, 8'h11);
    rdPulse();
    chk(cmdCnt + addrCnt + dataCnt == s0, "R13 strobes while deselected",
        cmdCnt + addrCnt + dataCnt - s0, 0);
    chk(colAddr == c0, "R13 column while deselected", colAddr, c0);
    @(negedge clk); reN = 1'b0;
    repeat (4) @(negedge clk);
    chk(ioOe == 1'b0, "R10 oe off deselected", ioOe, 0);
    reN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    t_recovery();
    t_cmd();
    t_addr();
    t_data();
    t_both();
    t_read_step();
    t_oe();
    t_busy(8'h30, RDB, "R7 read length");
    t_busy(8'h10, PGB, "R7 program length");
    t_busy_ignore();
    t_wp();
    t_ce_busy();
    t_ce_high();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule